// File: doc/BRIEF.md
# Dual-Channel Prescaled Pulse-Width Modulator

This block produces one pulse-width modulated output for each of its channels (two by default). Each channel owns a small set of 32-bit registers on a simple synchronous bus: a control word, a duty word and a period word. The input clock is first divided by a per-channel prescaler. The period count and the duty count then set, in prescaled ticks, how long one output cycle lasts and how long the output is high at the start of it.

Software programs a channel while it is idle and then sets its enable bit. Values written while the channel runs are held until the current output cycle ends, so no cycle is ever shortened or stretched. A channel can be stopped in one of two ways. It can finish its current cycle and then drop low, or it can drop low at once. Which one applies is chosen by a bit in its control word. A full-duty flag holds the output high for the whole cycle, whatever the duty count says.

Top module: `pwm_dual_ctrl`

## Requirements
- R1: Channel c has its registers at byte address 16*c: control at +0x0, duty at +0x4 and period at +0x8. The control word holds the prescale value PS in bits [5:0], the stop-mode select in bit 6 and the enable in bit 7. The duty word holds DC in bits [9:0] and the full-duty flag in bit 10. The period word holds PV in bits [9:0].
- R2: While a channel is enabled, its output repeats with a period of exactly (PS+1)*(PV+1) clocks. The first cycle starts on the second rising edge after the edge that writes the enable.
- R3: Within each output cycle, the output is high for the first (PS+1)*DC clocks and low for the rest.
- R4: When the full-duty flag is set, the output is high for the whole cycle and DC has no effect.
- R5: A DC of zero keeps the output low for the whole cycle. A DC of PV+1 or more keeps it high for the whole cycle.
- R6: When enable is cleared with the stop-mode bit set, the output is low from the second rising edge after the write onwards.
- R7: When enable is cleared with the stop-mode bit clear, the current output cycle completes unchanged and the output stays low afterwards.
- R8: New prescale, duty and period values written while a channel runs take effect only at the start of the next output cycle.
- R9: After reset all registers read zero and all outputs are low. A channel that is not enabled and not finishing a cycle keeps its output low.
- R10: Reads return the stored register fields with all unused bits zero. Addresses that map to no register read as zero.
- R11: Writes to and activity on one channel do not change the registers or the output of another channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (5) | Byte address of the register being accessed |
| bus_we | input | 1 | Write strobe; the write takes effect on the next rising edge |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr, available in the same cycle |
| pwm_out | output | NUM_CH (2) | One modulated output per channel |

## Verification
The bench builds the block with its default parameters: two channels, a 6-bit prescaler and 10-bit period and duty fields. With these widths the extreme corners are short enough to run. They include a prescale of 63, a period count of 1023, a duty count above the period, and the full-duty flag together with a zero duty count. The bench checks every output sample over whole cycles against a cycle-exact expected waveform. Writes are placed in the middle of a running cycle, so the bench can show where a deferred duty change first appears and where each of the two stop modes first drives the output low.

// File: rtl/pwm_pkg.sv
// Shared field widths, register layout and word types for the modulator.
// Assumes a 16-byte register window per channel, with the register select
// taken from address bits [3:2].
package pwm_pkg;
    localparam int PS_W      = 6;   // prescaler field width
    localparam int CNT_W     = 10;  // period / duty count width
    localparam int SPAN_LG   = 4;   // log2 of the per-channel byte window

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_DUTY = 2'd1,
        SEL_PER  = 2'd2
    } reg_sel_e;

    // Control word: bit7 enable, bit6 stop-at-once, bits[5:0] prescale
    typedef struct packed {
        logic            run;
        logic            halt_now;
        logic [PS_W-1:0] psc;
    } ctrl_t;

    // Duty word: bit10 full-duty flag, bits[9:0] high count
    typedef struct packed {
        logic             full;
        logic [CNT_W-1:0] hi_cnt;
    } duty_t;
endpackage

// File: rtl/pwm_regs.sv
// Register file and address decode for all channels.
// Assumes single-cycle writes and a combinational read path; a write to an
// unmapped address is dropped and a read of one returns zero.
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output ctrl_t             ctrl_o [NUM_CH],
    output duty_t             duty_o [NUM_CH],
    output logic [CNT_W-1:0]  per_o  [NUM_CH]
);
    localparam int CTRL_BITS = $bits(ctrl_t);
    localparam int DUTY_BITS = $bits(duty_t);

    logic [ADDR_W-1:0] ch_idx;
    logic              ch_hit;
    reg_sel_e          sel;
    logic              unused_addr;

    // Split the byte address into channel index and register select
    always_comb begin
        ch_idx = addr >> SPAN_LG;
        ch_hit = (ch_idx < ADDR_W'(NUM_CH));
        sel    = reg_sel_e'(addr[SPAN_LG-1:2]);
    end

    assign unused_addr = ^{addr[1:0], wdata[DATA_W-1:DUTY_BITS]};

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // Store the three words of channel c on a matching write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctrl_o[c] <= '0;
                duty_o[c] <= '0;
                per_o[c]  <= '0;
            end else if (we && ch_hit && ch_idx == ADDR_W'(c)) begin
                case (sel)
                    SEL_CTRL: ctrl_o[c] <= ctrl_t'(wdata[CTRL_BITS-1:0]);
                    SEL_DUTY: duty_o[c] <= duty_t'(wdata[DUTY_BITS-1:0]);
                    SEL_PER:  per_o[c]  <= wdata[CNT_W-1:0];
                    default:  ;
                endcase
            end
        end
    end

    // Return the addressed word, zero-extended, or zero when unmapped
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch_hit && ch_idx == ADDR_W'(i)) begin
                case (sel)
                    SEL_CTRL: rdata = DATA_W'(ctrl_o[i]);
                    SEL_DUTY: rdata = DATA_W'(duty_o[i]);
                    SEL_PER:  rdata = DATA_W'(per_o[i]);
                    default:  rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/pwm_chan.sv
// One modulator channel: prescale counter, period counter and the active
// copy of its settings. The settings are copied from the registers on
// start-up and at each cycle boundary only. Assumes the register outputs
// are synchronous to clk.
module pwm_chan
    import pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  ctrl_t            ctrl_i,
    input  duty_t            duty_i,
    input  logic [CNT_W-1:0] per_i,
    output logic             pwm_o,
    output logic             running_o,
    output logic [PS_W-1:0]  pre_cnt_o,
    output logic [CNT_W-1:0] per_cnt_o,
    output logic [PS_W-1:0]  psc_act_o,
    output logic [CNT_W-1:0] per_act_o,
    output duty_t            duty_act_o
);
    logic             running;
    logic [PS_W-1:0]  pre_cnt;
    logic [CNT_W-1:0] per_cnt;
    logic [PS_W-1:0]  psc_act;
    logic [CNT_W-1:0] per_act;
    duty_t            duty_act;
    logic             tick;
    logic             wrap;

    assign tick = (pre_cnt == psc_act);
    assign wrap = tick && (per_cnt == per_act);

    // Advance the counters, take new settings at boundaries, handle stops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running  <= 1'b0;
            pre_cnt  <= '0;
            per_cnt  <= '0;
            psc_act  <= '0;
            per_act  <= '0;
            duty_act <= '0;
        end else if (!running) begin
            if (ctrl_i.run) begin
                running  <= 1'b1;
                pre_cnt  <= '0;
                per_cnt  <= '0;
                psc_act  <= ctrl_i.psc;
                per_act  <= per_i;
                duty_act <= duty_i;
            end
        end else if (!ctrl_i.run && ctrl_i.halt_now) begin
            running <= 1'b0;
            pre_cnt <= '0;
            per_cnt <= '0;
        end else if (wrap) begin
            pre_cnt <= '0;
            per_cnt <= '0;
            if (ctrl_i.run) begin
                psc_act  <= ctrl_i.psc;
                per_act  <= per_i;
                duty_act <= duty_i;
            end else begin
                running <= 1'b0;
            end
        end else if (tick) begin
            pre_cnt <= '0;
            per_cnt <= per_cnt + 1'b1;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    // Drive high during the leading part of the cycle, or always when full
    always_comb begin
        pwm_o = running && (duty_act.full || (per_cnt < duty_act.hi_cnt));
    end

    assign running_o  = running;
    assign pre_cnt_o  = pre_cnt;
    assign per_cnt_o  = per_cnt;
    assign psc_act_o  = psc_act;
    assign per_act_o  = per_act;
    assign duty_act_o = duty_act;
endmodule

// File: rtl/pwm_dual_ctrl.sv
// Top level: register file plus one modulator engine per channel.
// Assumes ADDR_W is wide enough to hold NUM_CH register windows.
module pwm_dual_ctrl
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    ctrl_t             ctrl_w     [NUM_CH];
    duty_t             duty_w     [NUM_CH];
    logic [CNT_W-1:0]  per_w      [NUM_CH];
    logic [NUM_CH-1:0] running_w;
    logic [PS_W-1:0]   pre_cnt_w  [NUM_CH];
    logic [CNT_W-1:0]  per_cnt_w  [NUM_CH];
    logic [PS_W-1:0]   psc_act_w  [NUM_CH];
    logic [CNT_W-1:0]  per_act_w  [NUM_CH];
    duty_t             duty_act_w [NUM_CH];

    pwm_regs #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (bus_addr),
        .we     (bus_we),
        .wdata  (bus_wdata),
        .rdata  (bus_rdata),
        .ctrl_o (ctrl_w),
        .duty_o (duty_w),
        .per_o  (per_w)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_eng
        pwm_chan u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .ctrl_i     (ctrl_w[c]),
            .duty_i     (duty_w[c]),
            .per_i      (per_w[c]),
            .pwm_o      (pwm_out[c]),
            .running_o  (running_w[c]),
            .pre_cnt_o  (pre_cnt_w[c]),
            .per_cnt_o  (per_cnt_w[c]),
            .psc_act_o  (psc_act_w[c]),
            .per_act_o  (per_act_w[c]),
            .duty_act_o (duty_act_w[c])
        );
    end
endmodule

// File: rtl/pwm_dual_ctrl_chk.sv
// Property checker for pwm_dual_ctrl, attached by the bind below.
// Observes the register outputs, the engine state and the pin outputs.
module pwm_dual_ctrl_chk
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] pwm_out,
    input ctrl_t             ctrl_w     [NUM_CH],
    input logic [NUM_CH-1:0] running_w,
    input logic [PS_W-1:0]   pre_cnt_w  [NUM_CH],
    input logic [CNT_W-1:0]  per_cnt_w  [NUM_CH],
    input logic [PS_W-1:0]   psc_act_w  [NUM_CH],
    input logic [CNT_W-1:0]  per_act_w  [NUM_CH],
    input duty_t             duty_act_w [NUM_CH]
);
    AST_RESET_LOW: assert property (@(posedge clk) !rst_n |=> pwm_out == '0); // R9

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        AST_HALT_AT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
            (!ctrl_w[c].run && ctrl_w[c].halt_now) |=> !pwm_out[c]); // R6
        AST_PRESCALE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            running_w[c] |-> pre_cnt_w[c] <= psc_act_w[c]); // R2
        AST_PERIOD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            running_w[c] |-> per_cnt_w[c] <= per_act_w[c]); // R2
        AST_HOLD_MID_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(running_w[c]) && running_w[c] && (pre_cnt_w[c] != '0 || per_cnt_w[c] != '0))
            |-> ($stable(psc_act_w[c]) && $stable(per_act_w[c]) && $stable(duty_act_w[c]))); // R8
        AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (!running_w[c] && !ctrl_w[c].run) |=> !pwm_out[c]); // R9
    end
endmodule

bind pwm_dual_ctrl pwm_dual_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwm_out    (pwm_out),
    .ctrl_w     (ctrl_w),
    .running_w  (running_w),
    .pre_cnt_w  (pre_cnt_w),
    .per_cnt_w  (per_cnt_w),
    .psc_act_w  (psc_act_w),
    .per_act_w  (per_act_w),
    .duty_act_w (duty_act_w)
);

// File: tb/tb_pwm_dual_ctrl.sv
`timescale 1ns/1ps
module tb_pwm_dual_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  pwm_out;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwm_dual_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = 5'(a);
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic bus_read(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = 5'(a);
        #1 d = bus_rdata;
    endtask

    // Expected level at sample pos of a running channel (R2, R3, R4, R5)
    function automatic bit exp_lvl(input int pos, input int ps, input int pv,
                                   input int dc, input bit full);
        int per_len = (ps + 1) * (pv + 1);
        int slot = (pos % per_len) / (ps + 1);
        return full || (slot < dc);
    endfunction

    function automatic logic [31:0] ctrl_word(input bit en, input bit sd, input int ps);
        return (32'(en) << 7) | (32'(sd) << 6) | 32'(ps);
    endfunction

    // mode 0: plain; 1: duty rewrite mid-cycle; 2: finishing stop; 3: immediate stop
    task automatic run_wave(input int ch, input int ps, input int pv, input int dc,
                            input bit full, input int nsamp, input int wr_at,
                            input int mode, input int ndc, input bit nfull,
                            input string req);
        int base = 16 * ch;
        int per_len = (ps + 1) * (pv + 1);
        int bad_j = -1;
        bit bad_act = 1'b0;
        bit bad_exp = 1'b0;
        bit other_bad = 1'b0;
        bus_write(base + 4, (32'(full) << 10) | 32'(dc));
        bus_write(base + 8, 32'(pv));
        bus_write(base, ctrl_word(1'b1, 1'b0, ps));
        for (int j = 0; j < nsamp; j++) begin
            bit e;
            @(negedge clk);
            e = exp_lvl(j, ps, pv, dc, full);
            if (mode == 1 && j >= per_len) e = exp_lvl(j, ps, pv, ndc, nfull);
            if (mode == 2 && j >= (((wr_at + 1) / per_len) + 1) * per_len) e = 1'b0;
            if (mode == 3 && j >= wr_at + 2) e = 1'b0;
            if (pwm_out[ch] !== e && bad_j < 0) begin
                bad_j = j;
                bad_act = pwm_out[ch];
                bad_exp = e;
            end
            if (pwm_out[1 - ch] !== 1'b0) other_bad = 1'b1;
            if (mode != 0 && j == wr_at) begin
                bus_we = 1'b1;
                if (mode == 1) begin
                    bus_addr  = 5'(base + 4);
                    bus_wdata = (32'(nfull) << 10) | 32'(ndc);
                end else begin
                    bus_addr  = 5'(base);
                    bus_wdata = ctrl_word(1'b0, mode == 3, ps);
                end
            end
            if (j == wr_at + 1) bus_we = 1'b0;
        end
        bus_we = 1'b0;
        if (bad_j >= 0)
            $display("  mismatch at sample %0d ch%0d ps=%0d pv=%0d dc=%0d full=%0d",
                     bad_j, ch, ps, pv, dc, full);
        check(bad_j < 0, req, "waveform sample", 32'(bad_act), 32'(bad_exp));
        check(!other_bad, "R11", "idle channel stayed low", 32'(other_bad), 32'd0);
        bus_write(base, ctrl_word(1'b0, 1'b1, 0));
        bus_write(base, 32'd0);
    endtask

    initial begin
        logic [31:0] rd;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: registers clear and outputs low after reset
        for (int a = 0; a < 32; a += 4) begin
            bus_read(a, rd);
            check(rd == 32'd0, "R9", "reset register value", rd, 32'd0);
        end
        check(pwm_out == 2'b00, "R9", "outputs after reset", 32'(pwm_out), 32'd0);

        // R10 / R1 / R11: field masks on channel 1, channel 0 untouched
        bus_write(16 + 8, 32'hFFFF_FFFF);
        bus_write(16 + 4, 32'hFFFF_FFFF);
        bus_write(16 + 0, 32'hFFFF_FF3F);
        bus_read(16 + 8, rd);
        check(rd == 32'h3FF, "R10", "period readback", rd, 32'h3FF);
        bus_read(16 + 4, rd);
        check(rd == 32'h7FF, "R10", "duty readback", rd, 32'h7FF);
        bus_read(16 + 0, rd);
        check(rd == 32'h3F, "R1", "control readback", rd, 32'h3F);
        bus_read(16 + 12, rd);
        check(rd == 32'd0, "R10", "unmapped slot", rd, 32'd0);
        bus_read(4, rd);
        check(rd == 32'd0, "R11", "channel 0 duty untouched", rd, 32'd0);
        check(pwm_out == 2'b00, "R9", "not enabled stays low", 32'(pwm_out), 32'd0);
        bus_write(16 + 0, 32'hC0);
        bus_read(16 + 0, rd);
        check(rd == 32'hC0, "R10", "enable and stop bits readback", rd, 32'hC0);
        bus_write(16 + 0, ctrl_word(1'b0, 1'b1, 0));
        bus_write(16 + 0, 32'd0);
        bus_write(16 + 4, 32'd0);
        bus_write(16 + 8, 32'd0);

        // Directed corners
        run_wave(0, 0, 4, 2, 1'b0, 15, 0, 0, 0, 1'b0, "R2");
        run_wave(1, 2, 3, 3, 1'b0, 24, 0, 0, 0, 1'b0, "R3");
        run_wave(0, 63, 2, 1, 1'b0, 384, 0, 0, 0, 1'b0, "R2");
        run_wave(1, 0, 1023, 512, 1'b0, 2048, 0, 0, 0, 1'b0, "R3");
        run_wave(0, 1, 5, 0, 1'b0, 24, 0, 0, 0, 1'b0, "R5");
        run_wave(0, 1, 5, 6, 1'b0, 24, 0, 0, 0, 1'b0, "R5");
        run_wave(1, 0, 5, 1023, 1'b0, 12, 0, 0, 0, 1'b0, "R5");
        run_wave(1, 1, 5, 0, 1'b1, 24, 0, 0, 0, 1'b0, "R4");
        run_wave(0, 1, 7, 2, 1'b0, 48, 5, 1, 6, 1'b0, "R8");
        run_wave(1, 0, 9, 7, 1'b0, 30, 3, 1, 1, 1'b1, "R8");
        run_wave(0, 0, 9, 4, 1'b0, 40, 13, 2, 0, 1'b0, "R7");
        run_wave(1, 1, 4, 5, 1'b0, 40, 12, 2, 0, 1'b0, "R7");
        run_wave(0, 0, 9, 4, 1'b0, 40, 13, 3, 0, 1'b0, "R6");
        run_wave(1, 1, 4, 5, 1'b1, 30, 6, 3, 0, 1'b0, "R6");

        // Constrained random configurations (R2, R3)
        for (int k = 0; k < 12; k++) begin
            int ch = int'($urandom % 2);
            int ps = int'($urandom % 4);
            int pv = int'($urandom % 12);
            int dc = int'($urandom % (pv + 3));
            bit full = ($urandom % 6) == 0;
            run_wave(ch, ps, pv, dc, full, 2 * (ps + 1) * (pv + 1), 0, 0, 0, 1'b0, "R3");
        end

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule